// File: doc/BRIEF.md
# Debug Port Receive Completion Handler

This block closes out one host-initiated read on a USB 2.0 debug port. A start pulse arms it, which marks the point at which the IN token has gone out. From then on it watches an abstract packet receiver. That receiver delivers bytes one at a time (the first byte is the PID) and ends each packet with an end strobe that carries the CRC verdict. A programmable timer runs alongside and ends the wait if nothing usable arrives.

When the transaction resolves, the block loads its status fields: a sticky completion flag, an error flag and a three-bit exception code. A packet of two or more bytes that passed CRC is data. For data, the block stores up to eight payload bytes, records the payload length and asks for an ACK handshake one cycle later. A valid one-byte packet is a handshake from the device: its PID is kept and no ACK is requested. A bad CRC, an empty packet or a timeout all report exception code 001 with the error flag set. Software clears the completion flag by writing a one to it, and that re-arms the block.

Top module: `dbg_rx_complete`

## Requirements
- R1: A start pulse is accepted only while no transaction is running and the completion flag is clear. A start pulse given while the flag is set is ignored: no ACK follows, the status fields keep their values, and bytes sent afterwards leave the PID field unchanged.
- R2: An end strobe with CRC good after two or more bytes sets the completion flag, clears the error flag and sets the exception field to 000.
- R3: For a data packet, the ACK request is high for exactly one clock cycle. That cycle is the one after the cycle in which the completion flag first reads 1. Each transaction produces at most one such pulse.
- R4: An end strobe with CRC good after exactly one byte sets the completion flag, clears the error flag, sets the exception field to 000, reports a length of 0 and requests no ACK.
- R5: An end strobe with CRC bad, or an end strobe with no bytes received, sets the completion flag, sets the error flag, loads exception code 001 and reports a length of 0, with no ACK.
- R6: With a limit of N, if no end strobe arrives, the completion flag rises N clock edges after the edge that accepted the start pulse, with error 1 and exception 001. A limit of 0 behaves as 1.
- R7: An end strobe in the same cycle as the timer expiry takes priority. The outcome follows the packet, not the timeout.
- R8: Payload byte k (k = 1..8, the byte after the PID being k = 1) is stored at `data_o[8*(k-1) +: 8]`. Bytes beyond the eighth payload byte are dropped. The length field of a data packet reports the payload count, capped at 8.
- R9: The first byte received after the start pulse is presented on the PID output.
- R10: The completion flag stays set until the clear input is high for one cycle, and the following cycle it reads 0.
- R11: After reset, the completion flag, error flag, exception field, ACK request, length and PID all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| go_i | input | 1 | Start pulse, IN token issued |
| done_clr_i | input | 1 | Write-one-to-clear of the completion flag |
| tmo_limit_i | input | TMO_W | Receive timeout in clock cycles |
| rx_byte_vld_i | input | 1 | Received byte strobe |
| rx_byte_i | input | 8 | Received byte, PID first |
| rx_end_i | input | 1 | End of packet strobe |
| rx_crc_ok_i | input | 1 | CRC verdict, sampled with rx_end_i |
| ack_req_o | output | 1 | One-cycle request to send an ACK handshake |
| done_o | output | 1 | Completion flag |
| error_o | output | 1 | Error flag |
| exc_o | output | 3 | Exception code |
| pid_o | output | 8 | Captured PID |
| len_o | output | $clog2(MAX_BYTES+1) | Payload length of the last data packet |
| data_o | output | 8*MAX_BYTES | Payload buffer |

## Verification
The end-of-packet strobe and the timer expiry can land on the same clock edge. In that case the block must decide between a good handshake completion and a timeout failure. The bench provokes this with a limit of four: it sends a one-byte packet early and places the end strobe exactly in the fourth cycle after the start was accepted. It then requires error 0, exception 000, the captured PID and no ACK. Separate runs with the same limit and no packet pin down the edge on which the timeout alone fires.

// File: rtl/dbg_rx_pkg.sv
package dbg_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACK
  } rx_state_e;

  typedef enum logic [1:0] {
    FIN_NONE,
    FIN_DATA,
    FIN_HSK,
    FIN_FAIL
  } rx_fin_e;

  localparam logic [2:0] EXC_NONE   = 3'b000;
  localparam logic [2:0] EXC_NO_PKT = 3'b001;
endpackage

// File: rtl/dbg_rx_timer.sv
module dbg_rx_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expire_o
);
  logic [TMO_W-1:0] cnt_q, cnt_d;
  logic [TMO_W:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + (TMO_W+1)'(1);
  // a limit of zero expires on the first waiting cycle, like a limit of one
  assign expire_o = run_i && (cnt_inc >= {1'b0, limit_i});

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)    cnt_d = '0;
    else if (run_i) cnt_d = cnt_inc[TMO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dbg_rx_capture.sv
module dbg_rx_capture #(
  parameter int MAX_BYTES = 8,
  parameter int CNT_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   en_i,
  input  logic                   byte_vld_i,
  input  logic [7:0]             byte_i,
  output logic [CNT_W-1:0]       cnt_eff_o,
  output logic [7:0]             pid_o,
  output logic [8*MAX_BYTES-1:0] data_o
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_BYTES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       pid_q, pid_d;
  logic             take;

  assign take      = en_i && byte_vld_i && (cnt_q != CNT_SAT);
  assign cnt_eff_o = cnt_q + CNT_W'(take);

  always_comb begin
    cnt_d = cnt_q;
    pid_d = pid_q;
    if (start_i)   cnt_d = '0;
    else if (take) cnt_d = cnt_q + CNT_W'(1);
    if (take && cnt_q == '0) pid_d = byte_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pid_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      pid_q <= pid_d;
    end
  end

  assign pid_o = pid_q;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_slot
    logic [7:0] slot_q;
    logic       slot_we;
    assign slot_we = take && (cnt_q == CNT_W'(g + 1));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       slot_q <= '0;
      else if (slot_we) slot_q <= byte_i;
    end
    assign data_o[8*g +: 8] = slot_q;
  end
endmodule

// File: rtl/dbg_rx_ctrl.sv
module dbg_rx_ctrl
  import dbg_rx_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic             done_clr_i,
  input  logic             rx_end_i,
  input  logic             crc_ok_i,
  input  logic [CNT_W-1:0] cnt_eff_i,
  input  logic             expire_i,
  output logic             start_o,
  output logic             wait_o,
  output logic             done_o,
  output logic             error_o,
  output logic [2:0]       exc_o,
  output logic [LEN_W-1:0] len_o,
  output logic             ack_o
);
  rx_state_e        state_q, state_d;
  rx_fin_e          fin;
  logic             done_q, done_d, err_q, err_d, ack_q, ack_d;
  logic [2:0]       exc_q, exc_d;
  logic [LEN_W-1:0] len_q, len_d;

  assign start_o = (state_q == ST_IDLE) && go_i && !done_q;
  assign wait_o  = (state_q == ST_WAIT);

  // packet end outranks a timer expiry in the same cycle
  always_comb begin
    fin = FIN_NONE;
    if (state_q == ST_WAIT) begin
      if (rx_end_i) begin
        if (crc_ok_i && cnt_eff_i >= CNT_W'(2))      fin = FIN_DATA;
        else if (crc_ok_i && cnt_eff_i == CNT_W'(1)) fin = FIN_HSK;
        else                                         fin = FIN_FAIL;
      end else if (expire_i) begin
        fin = FIN_FAIL;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    done_d  = done_q;
    err_d   = err_q;
    exc_d   = exc_q;
    len_d   = len_q;
    ack_d   = (state_q == ST_ACK);
    unique case (state_q)
      ST_IDLE: if (start_o) state_d = ST_WAIT;
      ST_WAIT: if (fin == FIN_DATA) state_d = ST_ACK;
               else if (fin != FIN_NONE) state_d = ST_IDLE;
      ST_ACK:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    if (fin != FIN_NONE) begin
      done_d = 1'b1;
      err_d  = (fin == FIN_FAIL);
      exc_d  = (fin == FIN_FAIL) ? EXC_NO_PKT : EXC_NONE;
      len_d  = (fin == FIN_DATA) ? LEN_W'(cnt_eff_i - CNT_W'(1)) : '0;
    end else if (done_clr_i) begin
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      exc_q   <= EXC_NONE;
      len_q   <= '0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      exc_q   <= exc_d;
      len_q   <= len_d;
      ack_q   <= ack_d;
    end
  end

  assign done_o  = done_q;
  assign error_o = err_q;
  assign exc_o   = exc_q;
  assign len_o   = len_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/dbg_rx_complete.sv
module dbg_rx_complete #(
  parameter int MAX_BYTES = 8,
  parameter int TMO_W     = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           go_i,
  input  logic                           done_clr_i,
  input  logic [TMO_W-1:0]               tmo_limit_i,
  input  logic                           rx_byte_vld_i,
  input  logic [7:0]                     rx_byte_i,
  input  logic                           rx_end_i,
  input  logic                           rx_crc_ok_i,
  output logic                           ack_req_o,
  output logic                           done_o,
  output logic                           error_o,
  output logic [2:0]                     exc_o,
  output logic [7:0]                     pid_o,
  output logic [$clog2(MAX_BYTES+1)-1:0] len_o,
  output logic [8*MAX_BYTES-1:0]         data_o
);
  localparam int CNT_W = $clog2(MAX_BYTES + 2);
  localparam int LEN_W = $clog2(MAX_BYTES + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             start, waiting, expire;
  logic [CNT_W-1:0] cnt_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dbg_rx_timer #(.TMO_W(TMO_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start_i  (start),
    .run_i    (waiting),
    .limit_i  (tmo_limit_i),
    .expire_o (expire)
  );

  dbg_rx_capture #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_capture (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start_i    (start),
    .en_i       (waiting),
    .byte_vld_i (rx_byte_vld_i),
    .byte_i     (rx_byte_i),
    .cnt_eff_o  (cnt_eff),
    .pid_o      (pid_o),
    .data_o     (data_o)
  );

  dbg_rx_ctrl #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .go_i       (go_i),
    .done_clr_i (done_clr_i),
    .rx_end_i   (rx_end_i),
    .crc_ok_i   (rx_crc_ok_i),
    .cnt_eff_i  (cnt_eff),
    .expire_i   (expire),
    .start_o    (start),
    .wait_o     (waiting),
    .done_o     (done_o),
    .error_o    (error_o),
    .exc_o      (exc_o),
    .len_o      (len_o),
    .ack_o      (ack_req_o)
  );
endmodule

// File: rtl/dbg_rx_complete_chk.sv
module dbg_rx_complete_chk #(
  parameter int MAX_BYTES = 8
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           done_clr_i,
  input logic                           ack_req_o,
  input logic                           done_o,
  input logic                           error_o,
  input logic [2:0]                     exc_o,
  input logic [$clog2(MAX_BYTES+1)-1:0] len_o
);
  p_ack_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |=> !ack_req_o);

  p_ack_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> ($past(done_o) && !error_o));

  p_exc_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && error_o) |-> (exc_o == 3'b001));

  p_exc_ok_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !error_o) |-> (exc_o == 3'b000));

  p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !done_clr_i) |=> done_o);

  p_done_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && done_clr_i) |=> !done_o);

  p_len_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(len_o) <= MAX_BYTES);
endmodule

bind dbg_rx_complete dbg_rx_complete_chk #(.MAX_BYTES(MAX_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done_clr_i (done_clr_i),
  .ack_req_o  (ack_req_o),
  .done_o     (done_o),
  .error_o    (error_o),
  .exc_o      (exc_o),
  .len_o      (len_o)
);

// File: tb/tb_dbg_rx_complete.sv
`timescale 1ns/1ps
module tb_dbg_rx_complete;
  localparam int MAX_BYTES = 8;
  localparam int TMO_W     = 16;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   go_i = 1'b0, done_clr_i = 1'b0;
  logic [TMO_W-1:0]       tmo_limit_i = '0;
  logic                   rx_byte_vld_i = 1'b0, rx_end_i = 1'b0, rx_crc_ok_i = 1'b0;
  logic [7:0]             rx_byte_i = '0;
  logic                   ack_req_o, done_o, error_o;
  logic [2:0]             exc_o;
  logic [7:0]             pid_o;
  logic [3:0]             len_o;
  logic [8*MAX_BYTES-1:0] data_o;

  always #10 clk = ~clk;

  dbg_rx_complete #(.MAX_BYTES(MAX_BYTES), .TMO_W(TMO_W)) dut (.*);

  typedef struct packed {
    logic [7:0] cfg; logic [3:0] n; logic crc; logic fin; logic [7:0] pid;
    logic ack; logic err; logic [2:0] exc; logic [3:0] len;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{8'd100, 4'd3,  1'b1, 1'b1, 8'hC3, 1'b1, 1'b0, 3'd0, 4'd2},
    '{8'd100, 4'd9,  1'b1, 1'b1, 8'h4B, 1'b1, 1'b0, 3'd0, 4'd8},
    '{8'd100, 4'd12, 1'b1, 1'b1, 8'hD2, 1'b1, 1'b0, 3'd0, 4'd8},
    '{8'd100, 4'd1,  1'b1, 1'b1, 8'h5A, 1'b0, 1'b0, 3'd0, 4'd0},
    '{8'd100, 4'd4,  1'b0, 1'b1, 8'hC3, 1'b0, 1'b1, 3'd1, 4'd0},
    '{8'd100, 4'd0,  1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 3'd1, 4'd0},
    '{8'd6,   4'd0,  1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 3'd1, 4'd0},
    '{8'd20,  4'd3,  1'b1, 1'b0, 8'hE1, 1'b0, 1'b1, 3'd1, 4'd0},
    '{8'd100, 4'd2,  1'b1, 1'b1, 8'h87, 1'b1, 1'b0, 3'd0, 4'd1}
  };

  int checks = 0, errors = 0, ack_cnt = 0, ack_early = 0;
  logic prev_done = 1'b0, finished = 1'b0;

  function automatic logic [7:0] byte_at(input logic [7:0] pid, input int k);
    return (k == 0) ? pid : pid + 8'(k * 29);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (ack_req_o) begin
      ack_cnt++;
      if (!prev_done) ack_early++;
    end
    prev_done = done_o;
  endtask

  task automatic clear_done();
    done_clr_i = 1'b1; step(); done_clr_i = 1'b0;
  endtask

  task automatic run_txn(input vec_t v);
    tmo_limit_i = TMO_W'(v.cfg);
    ack_cnt = 0; ack_early = 0;
    go_i = 1'b1; step(); go_i = 1'b0;
    for (int k = 0; k < int'(v.n); k++) begin
      rx_byte_vld_i = 1'b1; rx_byte_i = byte_at(v.pid, k); step();
    end
    rx_byte_vld_i = 1'b0;
    if (v.fin) begin
      rx_end_i = 1'b1; rx_crc_ok_i = v.crc; step();
      rx_end_i = 1'b0; rx_crc_ok_i = 1'b0;
    end
    repeat (v.fin ? 6 : int'(v.cfg) + 2) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step();
    // R11 reset values
    check("R11 done", done_o, 0);
    check("R11 error", error_o, 0);
    check("R11 exc", exc_o, 0);
    check("R11 ack", ack_cnt, 0);
    check("R11 len", len_o, 0);
    check("R11 pid", pid_o, 0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      vec_t  v;
      v = VEC[i];
      if (v.err) tag = v.fin ? "R5" : "R6";
      else       tag = v.ack ? "R2" : "R4";
      run_txn(v);
      check({tag, " done"}, done_o, 1);
      check({tag, " error"}, error_o, v.err);
      check({tag, " exc"}, exc_o, v.exc);
      check("R8 len", len_o, v.len);
      check("R3 ack count", ack_cnt, v.ack);
      check("R3 ack before done", ack_early, 0);
      if (v.n != 0) check("R9 pid", pid_o, v.pid);
      if (v.ack)
        for (int k = 1; k <= int'(v.len); k++)
          check("R8 slot", data_o[8*(k-1) +: 8], byte_at(v.pid, k));
      if (i == 0) begin
        repeat (10) step();
        check("R10 done sticky", done_o, 1);
      end
      clear_done();
      check("R10 done cleared", done_o, 0);
    end

    // R1: start while done is set is ignored
    run_txn(VEC[3]);
    run_txn('{8'd3, 4'd1, 1'b0, 1'b1, 8'h99, 1'b0, 1'b0, 3'd0, 4'd0});
    check("R1 pid kept", pid_o, 8'h5A);
    check("R1 error kept", error_o, 0);
    check("R1 no ack", ack_cnt, 0);
    clear_done();

    // R6 exact expiry with limit 4
    tmo_limit_i = 16'd4; go_i = 1'b1; step(); go_i = 1'b0;
    repeat (3) step();
    check("R6 not yet", done_o, 0);
    step();
    check("R6 expired", done_o, 1);
    check("R6 exc", exc_o, 1);
    clear_done();

    // R6 limit 0 acts as 1
    tmo_limit_i = 16'd0; go_i = 1'b1; step(); go_i = 1'b0;
    step();
    check("R6 zero limit", done_o, 1);
    clear_done();

    // R7 end strobe on the expiry edge
    ack_cnt = 0;
    tmo_limit_i = 16'd4; go_i = 1'b1; step(); go_i = 1'b0;
    rx_byte_vld_i = 1'b1; rx_byte_i = 8'h3C; step(); rx_byte_vld_i = 1'b0;
    step(); step();
    rx_end_i = 1'b1; rx_crc_ok_i = 1'b1; step();
    rx_end_i = 1'b0; rx_crc_ok_i = 1'b0;
    check("R7 done", done_o, 1);
    check("R7 error", error_o, 0);
    check("R7 exc", exc_o, 0);
    check("R7 pid", pid_o, 8'h3C);
    repeat (3) step();
    check("R7 no ack", ack_cnt, 0);
    clear_done();

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule